// File: doc/BRIEF.md
# Lockstep CPU output comparator

This block sits between two redundant processor cores running the same program in lockstep. Every clock it compares the compare bus of the master core with that of the checker core. When they differ, it raises a pulse on two separate error outputs that lead to the system error aggregator. A fault therefore still arrives if one of the two paths is broken. Right after reset the core outputs have not settled, so the block ignores the buses for a fixed hold-off of clock edges. After that it monitors continuously, with no software involvement.

Software selects an operating mode by writing a 4-bit key:

- **Lockstep** compares the two core buses.
- **Self-test** compares two pattern buses from an external pattern generator. It reports a fault when the comparison result disagrees with the expected outcome, and the compare error output stays silent.
- The two **forcing** modes each inject a single deliberate fault into one error path, to prove that path works. The block then falls back to lockstep on its own.

Both error outputs are also captured in sticky status flags. Software reads them on a small read port and clears them by writing 1 to the flag.

Top module: `lockstep_cmp`

## Requirements
- R1: While `rst_n` is low, and after it is released, the mode is lockstep (key 0x0), both sticky flags are 0, both error outputs are 0, and the armed status bit is 0.
- R2: Inputs present at the first HOLDOFF (default 6) rising edges after reset release cause no error pulse. Inputs at every later edge are compared. Status bit 2 (armed) reads 1 starting in the cycle after the HOLDOFF-th edge.
- R3: A write with `wr_sel`=0 loads the mode key from `wr_data` at that edge. The keys are 0x0 lockstep, 0x6 self-test, 0x9 error forcing and 0xF self-test error forcing. Any other value leaves the mode unchanged. Reading with `rd_sel`=0 returns the current key.
- R4: In lockstep, an armed edge that samples any bit difference between `master_bus` and `checker_bus` makes `cmp_err_o` high for exactly the following cycle. Each mismatching edge produces its own pulse.
- R5: That same lockstep mismatch also makes `st_err_o` high in the same cycle.
- R6: In self-test, `cmp_err_o` stays low whatever the buses do. `st_err_o` pulses after an armed edge where `pat_valid`=1 and the result of (`pat_a` != `pat_b`) differs from `pat_expect_diff`.
- R7: In error forcing, the first armed edge produces a `cmp_err_o` pulse with no `st_err_o` pulse. The mode then returns to lockstep.
- R8: In self-test error forcing, the first armed edge produces a `st_err_o` pulse with no `cmp_err_o` pulse. The mode then returns to lockstep.
- R9: Reading with `rd_sel`=1 returns {0, armed, self-test flag, compare flag}, with the compare flag in bit 0. Each flag is set together with its error pulse and stays set until it is cleared. A write with `wr_sel`=1 clears each flag whose `wr_data` bit (bit 0 compare, bit 1 self-test) is 1. A set in the same edge wins over a clear.
- R10: A valid key write on the same edge where a forcing mode would return to lockstep takes priority: the written key becomes the mode. The forced pulse of that edge is still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| master_bus | input | BUS_W | Compare bus of the master core |
| checker_bus | input | BUS_W | Compare bus of the checker core |
| pat_a | input | BUS_W | Self-test pattern, first operand |
| pat_b | input | BUS_W | Self-test pattern, second operand |
| pat_valid | input | 1 | Self-test pattern present this cycle |
| pat_expect_diff | input | 1 | Pattern is meant to mismatch |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mode key, 1 flag clear |
| wr_data | input | 4 | Write data |
| rd_sel | input | 1 | Read source: 0 mode key, 1 status |
| rd_data | output | 4 | Read data, combinational from state |
| cmp_err_o | output | 1 | Compare error pulse |
| st_err_o | output | 1 | Self-test error pulse |

## Verification
Error pulses are registered. A pulse is due in the cycle after the edge that sampled the offending inputs, and the sticky flags, the armed bit and the mode key are updated at that same edge. Read data is combinational from those registers, so it shows the new state in that cycle. Inputs are driven one time unit after each rising edge, and a behavioural model advances on the same edges. Every output is compared with the model at the falling edge, where all three results of the preceding edge have settled. The hold-off window is counted in edges from the bench's own reset release, so an off-by-one in the arming shows up as an early or missing pulse.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int KEY_W = 4;

  // Status bit positions on the read port
  localparam int STAT_CMP = 0;
  localparam int STAT_ST  = 1;
  localparam int STAT_ARM = 2;

  typedef enum logic [KEY_W-1:0] {
    MODE_LOCK   = 4'h0,
    MODE_SELF   = 4'h6,
    MODE_FORCE  = 4'h9,
    MODE_SFORCE = 4'hF
  } lsc_mode_e;

  function automatic logic key_valid(input logic [KEY_W-1:0] k);
    return (k == MODE_LOCK) || (k == MODE_SELF) ||
           (k == MODE_FORCE) || (k == MODE_SFORCE);
  endfunction

  function automatic logic is_forcing(input lsc_mode_e m);
    return (m == MODE_FORCE) || (m == MODE_SFORCE);
  endfunction

endpackage

// File: rtl/lsc_holdoff.sv
module lsc_holdoff #(
  parameter int HOLDOFF = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic armed_o
);

  localparam int CNT_W = (HOLDOFF < 1) ? 1 : $clog2(HOLDOFF + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HOLDOFF);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (cnt_q != CNT_END);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign armed_o = ~cnt_en;

endmodule

// File: rtl/lsc_mode_ctrl.sv
module lsc_mode_ctrl
  import lsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_data,
  input  logic             armed,
  output lsc_mode_e        mode_o
);

  lsc_mode_e mode_q;
  lsc_mode_e mode_d;
  logic      mode_en;

  always_comb begin
    mode_d  = mode_q;
    mode_en = 1'b0;
    if (key_we && key_valid(key_data)) begin
      mode_d  = lsc_mode_e'(key_data);
      mode_en = 1'b1;
    end else if (is_forcing(mode_q) && armed) begin
      // the single forced comparison happens this edge
      mode_d  = MODE_LOCK;
      mode_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_LOCK;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/lsc_compare.sv
module lsc_compare
  import lsc_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int LANE_W = 8
) (
  input  lsc_mode_e        mode,
  input  logic [BUS_W-1:0] master_bus,
  input  logic [BUS_W-1:0] checker_bus,
  input  logic [BUS_W-1:0] pat_a,
  input  logic [BUS_W-1:0] pat_b,
  output logic             diff_o
);

  localparam int LANES = BUS_W / LANE_W;

  logic [BUS_W-1:0] op_a;
  logic [BUS_W-1:0] op_b;
  logic [LANES-1:0] lane_diff;

  // Operand steering: the forcing modes feed a known pair through the
  // same XOR tree, so the real tree is what gets exercised.
  always_comb begin
    op_a = master_bus;
    op_b = checker_bus;
    unique case (mode)
      MODE_LOCK:   begin op_a = master_bus; op_b = checker_bus;  end
      MODE_SELF:   begin op_a = pat_a;      op_b = pat_b;        end
      MODE_FORCE:  begin op_a = master_bus; op_b = ~master_bus;  end
      MODE_SFORCE: begin op_a = master_bus; op_b = master_bus;   end
      default:     begin op_a = master_bus; op_b = checker_bus;  end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_diff[g] = |(op_a[g*LANE_W +: LANE_W] ^ op_b[g*LANE_W +: LANE_W]);
  end

  assign diff_o = |lane_diff;

endmodule

// File: rtl/lsc_report.sv
module lsc_report
  import lsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  lsc_mode_e  mode,
  input  logic       diff,
  input  logic       pat_valid,
  input  logic       pat_expect_diff,
  input  logic       clr_we,
  input  logic [1:0] clr_bits,
  output logic       cmp_pulse_o,
  output logic       st_pulse_o,
  output logic       cmp_flag_o,
  output logic       st_flag_o
);

  logic cmp_hit;
  logic st_hit;
  logic cmp_pulse_q;
  logic st_pulse_q;
  logic cmp_flag_q;
  logic cmp_flag_d;
  logic st_flag_q;
  logic st_flag_d;

  always_comb begin
    cmp_hit = 1'b0;
    st_hit  = 1'b0;
    if (armed) begin
      unique case (mode)
        MODE_LOCK: begin
          cmp_hit = diff;
          st_hit  = diff;   // second path for the same fault
        end
        MODE_SELF: begin
          st_hit = pat_valid && (diff != pat_expect_diff);
        end
        MODE_FORCE: begin
          cmp_hit = diff;
        end
        MODE_SFORCE: begin
          st_hit = (diff != 1'b1);
        end
        default: begin
          cmp_hit = 1'b0;
          st_hit  = 1'b0;
        end
      endcase
    end
    cmp_flag_d = cmp_hit | (cmp_flag_q & ~(clr_we & clr_bits[0]));
    st_flag_d  = st_hit  | (st_flag_q  & ~(clr_we & clr_bits[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_pulse_q <= 1'b0;
      st_pulse_q  <= 1'b0;
      cmp_flag_q  <= 1'b0;
      st_flag_q   <= 1'b0;
    end else begin
      cmp_pulse_q <= cmp_hit;
      st_pulse_q  <= st_hit;
      cmp_flag_q  <= cmp_flag_d;
      st_flag_q   <= st_flag_d;
    end
  end

  assign cmp_pulse_o = cmp_pulse_q;
  assign st_pulse_o  = st_pulse_q;
  assign cmp_flag_o  = cmp_flag_q;
  assign st_flag_o   = st_flag_q;

endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lsc_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int LANE_W  = 8,
  parameter int HOLDOFF = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] master_bus,
  input  logic [BUS_W-1:0] checker_bus,
  input  logic [BUS_W-1:0] pat_a,
  input  logic [BUS_W-1:0] pat_b,
  input  logic             pat_valid,
  input  logic             pat_expect_diff,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [3:0]       wr_data,
  input  logic             rd_sel,
  output logic [3:0]       rd_data,
  output logic             cmp_err_o,
  output logic             st_err_o
);

  logic      armed;
  lsc_mode_e mode;
  logic      diff;
  logic      cmp_flag;
  logic      st_flag;
  logic      key_we;
  logic      clr_we;

  assign key_we = wr_en & ~wr_sel;
  assign clr_we = wr_en &  wr_sel;

  lsc_holdoff #(.HOLDOFF(HOLDOFF)) u_holdoff (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed_o (armed)
  );

  lsc_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (key_we),
    .key_data (wr_data),
    .armed    (armed),
    .mode_o   (mode)
  );

  lsc_compare #(.BUS_W(BUS_W), .LANE_W(LANE_W)) u_compare (
    .mode        (mode),
    .master_bus  (master_bus),
    .checker_bus (checker_bus),
    .pat_a       (pat_a),
    .pat_b       (pat_b),
    .diff_o      (diff)
  );

  lsc_report u_report (
    .clk             (clk),
    .rst_n           (rst_n),
    .armed           (armed),
    .mode            (mode),
    .diff            (diff),
    .pat_valid       (pat_valid),
    .pat_expect_diff (pat_expect_diff),
    .clr_we          (clr_we),
    .clr_bits        (wr_data[1:0]),
    .cmp_pulse_o     (cmp_err_o),
    .st_pulse_o      (st_err_o),
    .cmp_flag_o      (cmp_flag),
    .st_flag_o       (st_flag)
  );

  always_comb begin
    rd_data = 4'h0;
    if (rd_sel) begin
      rd_data[STAT_CMP] = cmp_flag;
      rd_data[STAT_ST]  = st_flag;
      rd_data[STAT_ARM] = armed;
    end else begin
      rd_data = mode;
    end
  end

endmodule

// File: rtl/lsc_checker.sv
module lsc_checker
  import lsc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      armed,
  input lsc_mode_e mode,
  input logic      wr_en,
  input logic      wr_sel,
  input logic [3:0] wr_data,
  input logic      cmp_err_o,
  input logic      st_err_o,
  input logic      cmp_flag
);

  AST_QUIET_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!cmp_err_o && !st_err_o)); // R2

  AST_BAD_KEY_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !key_valid(wr_data) && !is_forcing(mode)) |=> $stable(mode)); // R3

  AST_DUAL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_err_o && $past(mode) == MODE_LOCK) |-> st_err_o); // R5

  AST_SELF_MUTES_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SELF) |=> !cmp_err_o); // R6

  AST_FORCE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FORCE && armed && !(wr_en && !wr_sel))
      |=> (mode == MODE_LOCK && cmp_err_o && !st_err_o)); // R7

  AST_SFORCE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SFORCE && armed && !(wr_en && !wr_sel))
      |=> (mode == MODE_LOCK && st_err_o && !cmp_err_o)); // R8

  AST_FLAG_FOLLOWS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_err_o |-> cmp_flag); // R9

  AST_KEY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && key_valid(wr_data)) |=> (mode == $past(wr_data))); // R10

endmodule

bind lockstep_cmp lsc_checker i_lsc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .armed     (armed),
  .mode      (mode),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .cmp_err_o (cmp_err_o),
  .st_err_o  (st_err_o),
  .cmp_flag  (cmp_flag)
);

// File: tb/test_lockstep_cmp.sv
// One delay unit stands for 1 ns: a 4-unit period gives 250 MHz.
module test_lockstep_cmp;

  localparam int BW   = 32;
  localparam int HOLD = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [BW-1:0] master_bus = '0;
  logic [BW-1:0] checker_bus = '0;
  logic [BW-1:0] pat_a = '0;
  logic [BW-1:0] pat_b = '0;
  logic          pat_valid = 1'b0;
  logic          pat_expect_diff = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [3:0]    wr_data = 4'h0;
  logic          rd_sel = 1'b0;
  logic [3:0]    rd_data;
  logic          cmp_err_o;
  logic          st_err_o;

  int checks = 0;
  int errors = 0;

  lockstep_cmp #(.BUS_W(BW), .LANE_W(8), .HOLDOFF(HOLD)) i_lockstep_cmp (
    .clk             (clk),
    .rst_n           (rst_n),
    .master_bus      (master_bus),
    .checker_bus     (checker_bus),
    .pat_a           (pat_a),
    .pat_b           (pat_b),
    .pat_valid       (pat_valid),
    .pat_expect_diff (pat_expect_diff),
    .wr_en           (wr_en),
    .wr_sel          (wr_sel),
    .wr_data         (wr_data),
    .rd_sel          (rd_sel),
    .rd_data         (rd_data),
    .cmp_err_o       (cmp_err_o),
    .st_err_o        (st_err_o)
  );

  always #2 clk = ~clk;

  // ---------------- reference model ----------------
  int    m_mode = 0;
  int    m_cnt  = 0;
  bit    m_cf = 1'b0, m_sf = 1'b0, m_cp = 1'b0, m_sp = 1'b0;
  bit    m_in_rst = 1'b1;
  bit    m_prio = 1'b0;
  bit    m_armed, m_cp_n, m_sp_n, m_keyok;
  string tag_c = "R1";
  string tag_s = "R1";

  function automatic bit valid_key(input int k);
    return (k == 0) || (k == 6) || (k == 9) || (k == 15);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_cf = 0; m_sf = 0; m_cp = 0; m_sp = 0;
      m_in_rst = 1; m_prio = 0; tag_c = "R1"; tag_s = "R1";
    end else begin
      m_in_rst = 0;
      m_armed  = (m_cnt >= HOLD);
      m_cp_n   = 0;
      m_sp_n   = 0;
      case (m_mode)
        0: begin
          m_cp_n = m_armed && (master_bus != checker_bus);
          m_sp_n = m_cp_n;
          tag_c = "R4"; tag_s = "R5";
        end
        6: begin
          m_sp_n = m_armed && pat_valid && ((pat_a != pat_b) != pat_expect_diff);
          tag_c = "R6"; tag_s = "R6";
        end
        9: begin
          m_cp_n = m_armed;
          tag_c = "R7"; tag_s = "R7";
        end
        default: begin
          m_sp_n = m_armed;
          tag_c = "R8"; tag_s = "R8";
        end
      endcase
      if (!m_armed) begin
        tag_c = "R2"; tag_s = "R2";
      end
      m_keyok = wr_en && !wr_sel && valid_key(int'(wr_data));
      m_prio  = m_keyok && m_armed && (m_mode == 9 || m_mode == 15);
      if (m_keyok) m_mode = int'(wr_data);
      else if (m_armed && (m_mode == 9 || m_mode == 15)) m_mode = 0;
      m_cf = m_cp_n | (m_cf & !(wr_en && wr_sel && wr_data[0]));
      m_sf = m_sp_n | (m_sf & !(wr_en && wr_sel && wr_data[1]));
      if (m_cnt < HOLD) m_cnt++;
      m_cp = m_cp_n;
      m_sp = m_sp_n;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    logic [3:0] exp_rd;
    string      tag_r;
    if (rd_sel) begin
      exp_rd = {1'b0, (m_cnt >= HOLD), m_sf, m_cf};
      tag_r  = (m_cnt >= HOLD) ? "R9" : "R2";
    end else begin
      exp_rd = 4'(m_mode);
      tag_r  = m_prio ? "R10" : "R3";
    end
    if (m_in_rst) tag_r = "R1";
    chk(tag_c, "cmp_err_o", int'(cmp_err_o), int'(m_cp));
    chk(tag_s, "st_err_o",  int'(st_err_o),  int'(m_sp));
    chk(tag_r, "rd_data",   int'(rd_data),   int'(exp_rd));
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic key_write(input logic [3:0] k);
    wr_en = 1; wr_sel = 0; wr_data = k;
    tick();
    wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  initial begin
    #1 rst_n = 0;
    master_bus  = 32'hA5A5_0001;
    checker_bus = 32'h5A5A_0001;
    rd_sel = 1;
    repeat (3) tick();
    rst_n = 1;
    // R2: mismatch held across the hold-off window and beyond
    repeat (9) tick();
    // R9: clear both flags while buses agree
    checker_bus = master_bus;
    wr_en = 1; wr_sel = 1; wr_data = 4'h3;
    tick();
    wr_en = 0;
    // R4 R5: mixed lockstep traffic, single-bit faults in all lanes
    for (int i = 0; i < 60; i++) begin
      master_bus  = $urandom;
      checker_bus = (($urandom % 4) == 0) ? (master_bus ^ (32'h1 << ($urandom % 32))) : master_bus;
      rd_sel = $urandom % 2;
      if (($urandom % 8) == 0) begin
        wr_en = 1; wr_sel = 1; wr_data = 4'($urandom % 4);
      end else begin
        wr_en = 0;
      end
      tick();
    end
    wr_en = 0;
    checker_bus = master_bus;
    // R3: unknown key ignored
    rd_sel = 0;
    key_write(4'h5);
    tick();
    // R6: self-test with mismatching core buses
    key_write(4'h6);
    for (int i = 0; i < 30; i++) begin
      master_bus      = $urandom;
      checker_bus     = ~master_bus;
      pat_a           = $urandom;
      pat_b           = (($urandom % 2) == 0) ? pat_a : pat_a ^ 32'h0100_0000;
      pat_valid       = $urandom % 2;
      pat_expect_diff = $urandom % 2;
      rd_sel          = $urandom % 2;
      tick();
    end
    pat_valid = 0;
    key_write(4'hA);
    // R7: forced compare error then automatic lockstep
    key_write(4'h0);
    checker_bus = master_bus;
    rd_sel = 0;
    key_write(4'h9);
    repeat (3) tick();
    // R10: key write on the forcing edge wins
    key_write(4'h9);
    key_write(4'h6);
    tick();
    key_write(4'h0);
    // R8: forced self-test error
    key_write(4'hF);
    repeat (3) tick();
    // R9: set and clear on the same edge
    rd_sel = 1;
    checker_bus = master_bus ^ 32'h8000_0000;
    wr_en = 1; wr_sel = 1; wr_data = 4'h3;
    tick();
    wr_en = 0;
    checker_bus = master_bus;
    tick();
    wr_en = 1; wr_sel = 1; wr_data = 4'h1;
    tick();
    wr_en = 0;
    tick();
    // R2 R7: forcing requested during hold-off waits for arming
    do_reset();
    rd_sel = 0;
    key_write(4'h9);
    repeat (9) tick();
    // R1: reset in the middle of activity
    checker_bus = ~master_bus;
    tick();
    do_reset();
    repeat (4) tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule